// File: doc/BRIEF.md
# Alternating Pattern Detector

This block watches a received E1 bit stream for an alternating one-zero pattern. It runs only while basic frame alignment is lost. The enabled bits are grouped into pairs that do not overlap. Each pair whose first bit is 1 and whose second bit is 0 counts as a hit. A fixed window of 256 pairs covers 250 µs at 2.048 Mbit/s. When a window closes with at least 254 hits, the status output sets. When a window closes with fewer hits, the status output clears.

The status drives an interrupt pulse when it rises. An alarm simulation input forces the status on. When simulation is removed, the status returns to whatever the real detection holds. While frame alignment is present, all counting state is held at zero, so the pattern cannot be reported.

Top module: `aux_pattern_det`

## Requirements
- R1: After reset, `aux_o` and `aux_irq_o` are 0.
- R2: Pairing starts with the first enabled bit after `lfa_i` goes high, and the pairs do not overlap. The first bit of a pair comes first in time. Only a pair with first bit 1 and second bit 0 counts as a hit, so a stream shifted by one bit (pairs 0 then 1) gives no hits.
- R3: Each window is 256 pairs long. On the clock edge that samples the last bit of a window, the status sets if the window held 254 or more hits.
- R4: On the clock edge that samples the last bit of a window, the status clears if the window held fewer than 254 hits and simulation is off.
- R5: Within a window the status does not change, except through `lfa_i` or `sim_i`.
- R6: While `lfa_i` is 0, the status clears on the next edge unless simulation is on. The pair phase and both counters also reset, so the next window is a full 256 pairs after `lfa_i` returns.
- R7: A bit is ignored on any cycle where `bit_en_i` is 0.
- R8: `aux_irq_o` is a one-cycle pulse in the same cycle that `aux_o` rises, and is 0 at all other times.
- R9: When `sim_i` is 1, `aux_o` is 1 from the next edge on. If that makes `aux_o` rise, the interrupt of R8 fires.
- R10: When `sim_i` returns to 0, `aux_o` shows the real detection result: it clears if no pattern was detected and stays set, with no new interrupt, if one was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received data bit |
| bit_en_i | input | 1 | Marks `bit_i` as valid this cycle |
| lfa_i | input | 1 | 1 while basic frame alignment is lost |
| sim_i | input | 1 | Alarm simulation, forces the status on |
| aux_o | output | 1 | Auxiliary pattern status |
| aux_irq_o | output | 1 | One-cycle pulse when `aux_o` rises |

## Verification
The bench sweeps the hit count per window across every value from 240 to 256, which brackets the threshold. An off-by-one compare or an inclusive/exclusive mix-up would show as a wrong status at 253 or 254. A stream shifted by one bit checks the pair phase: a design that counts overlapping pairs or starts pairing on the wrong bit would report the shifted pattern. A drop of alignment in the middle of a window, followed by a count that lands on the old window boundary, catches a window counter that is not reset. Simulation is applied both with and without a real detection, which exposes a design that clears a genuine status on release or fires a second interrupt.

// File: rtl/aux_pkg.sv
package aux_pkg;
  typedef struct packed {
    logic valid;  // second bit of a pair sampled this cycle
    logic hit;    // that pair was 1 then 0
  } pair_t;
endpackage

// File: rtl/pair_framer.sv
module pair_framer
  import aux_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  bit_i,
  input  logic  bit_en_i,
  input  logic  run_i,
  output pair_t pair_o
);
  logic phase_q;
  logic first_q;
  logic take;

  assign take = bit_en_i & run_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      first_q <= 1'b0;
    end else if (!run_i) begin
      phase_q <= 1'b0;
      first_q <= 1'b0;
    end else if (take) begin
      phase_q <= ~phase_q;
      if (!phase_q) first_q <= bit_i;
    end
  end

  always_comb begin
    pair_o.valid = take & phase_q;
    pair_o.hit   = take & phase_q & first_q & ~bit_i;
  end
endmodule

// File: rtl/pair_window.sv
module pair_window
  import aux_pkg::*;
#(
  parameter int unsigned WIN_PAIRS = 256,
  parameter int unsigned THRESH    = 254
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  pair_t pair_i,
  output logic  win_end_o,
  output logic  win_met_o
);
  localparam int unsigned PW = $clog2(WIN_PAIRS);
  localparam int unsigned HW = $clog2(WIN_PAIRS + 1);
  localparam logic [PW-1:0] LAST = PW'(WIN_PAIRS - 1);

  logic [PW-1:0] pair_cnt_q;
  logic [HW-1:0] hit_cnt_q;
  logic [HW-1:0] hit_total;

  assign hit_total = hit_cnt_q + HW'(pair_i.hit);
  assign win_end_o = pair_i.valid & (pair_cnt_q == LAST);
  assign win_met_o = win_end_o & (hit_total >= HW'(THRESH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_cnt_q <= '0;
      hit_cnt_q  <= '0;
    end else if (!run_i) begin
      pair_cnt_q <= '0;
      hit_cnt_q  <= '0;
    end else if (pair_i.valid) begin
      if (win_end_o) begin
        pair_cnt_q <= '0;
        hit_cnt_q  <= '0;
      end else begin
        pair_cnt_q <= pair_cnt_q + 1'b1;
        hit_cnt_q  <= hit_total;
      end
    end
  end
endmodule

// File: rtl/aux_status.sv
module aux_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sim_i,
  input  logic win_end_i,
  input  logic win_met_i,
  output logic aux_o,
  output logic irq_o
);
  logic real_q, real_d;
  logic aux_q, aux_d;
  logic irq_q;

  always_comb begin
    real_d = real_q;
    if (!run_i)         real_d = 1'b0;
    else if (win_end_i) real_d = win_met_i;
    aux_d = real_d | sim_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      real_q <= 1'b0;
      aux_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      real_q <= real_d;
      aux_q  <= aux_d;
      irq_q  <= aux_d & ~aux_q;
    end
  end

  assign aux_o = aux_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/aux_pattern_det.sv
module aux_pattern_det
  import aux_pkg::*;
#(
  parameter int unsigned WIN_PAIRS = 256,
  parameter int unsigned THRESH    = 254
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_en_i,
  input  logic lfa_i,
  input  logic sim_i,
  output logic aux_o,
  output logic aux_irq_o
);
  pair_t pair;
  logic  win_end, win_met;

  pair_framer u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .bit_i   (bit_i),
    .bit_en_i(bit_en_i),
    .run_i   (lfa_i),
    .pair_o  (pair)
  );

  pair_window #(
    .WIN_PAIRS(WIN_PAIRS),
    .THRESH   (THRESH)
  ) u_window (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (lfa_i),
    .pair_i   (pair),
    .win_end_o(win_end),
    .win_met_o(win_met)
  );

  aux_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (lfa_i),
    .sim_i    (sim_i),
    .win_end_i(win_end),
    .win_met_i(win_met),
    .aux_o    (aux_o),
    .irq_o    (aux_irq_o)
  );
endmodule

// File: rtl/aux_pattern_det_chk.sv
module aux_pattern_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic lfa_i,
  input logic sim_i,
  input logic aux_o,
  input logic aux_irq_o
);
  p_irq_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_irq_o |-> (aux_o && !$past(aux_o)));

  p_irq_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_irq_o |=> !aux_irq_o);

  p_sim_forces_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sim_i |=> aux_o);

  p_aligned_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lfa_i && !sim_i) |=> !aux_o);

  p_rise_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_o) |-> ($past(sim_i) || $past(bit_en_i && lfa_i)));

  p_rise_has_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_o) |-> aux_irq_o);
endmodule

bind aux_pattern_det aux_pattern_det_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_en_i (bit_en_i),
  .lfa_i    (lfa_i),
  .sim_i    (sim_i),
  .aux_o    (aux_o),
  .aux_irq_o(aux_irq_o)
);

// File: tb/aux_pattern_det_test.sv
`timescale 1ns/1ps
module aux_pattern_det_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_v = 1'b0, bit_en = 1'b0, lfa = 1'b0, sim = 1'b0;
  logic aux, irq;
  int   n_run = 0, n_fail = 0;
  int   irq_seen = 0, irq_exp = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  aux_pattern_det uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_v), .bit_en_i(bit_en),
    .lfa_i(lfa), .sim_i(sim), .aux_o(aux), .aux_irq_o(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_seen++;

  task automatic chk(input logic act, input logic exp, input string req);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_v = b; bit_en = 1'b1;
  endtask

  task automatic idle_sample;
    @(negedge clk);
    bit_en = 1'b0; bit_v = 1'b0;
  endtask

  // n_hit pairs of 1,0 then 1,1 for the rest; gap>0 inserts disabled junk cycles (R7)
  task automatic send_pairs(input int n_pairs, input int n_hit, input int gap);
    for (int p = 0; p < n_pairs; p++) begin
      send_bit(1'b1);
      for (int g = 0; g < gap; g++) begin @(negedge clk); bit_en = 1'b0; bit_v = 1'b0; end
      send_bit(p < n_hit ? 1'b0 : 1'b1);
      for (int g = 0; g < gap; g++) begin @(negedge clk); bit_en = 1'b0; bit_v = 1'b1; end
    end
  endtask

  // full window; checks status held before the last bit and set/clear after it
  task automatic window(input int n_hit, input int gap, input string req);
    logic prev, exp;
    prev = aux;
    send_pairs(255, n_hit > 255 ? 255 : n_hit, gap);
    send_bit(1'b1);
    @(negedge clk); bit_en = 1'b0;
    chk(aux, prev, "R5 hold in window");
    bit_v = (n_hit >= 256) ? 1'b0 : 1'b1; bit_en = 1'b1;
    idle_sample;
    exp = (n_hit >= 254);
    chk(aux, exp, req);
    chk(irq, exp & ~prev, "R8 irq on rise");
    if (exp & ~prev) irq_exp++;
    idle_sample;
    chk(irq, 1'b0, "R8 irq one cycle");
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(aux, 1'b0, "R1 reset aux");
    chk(irq, 1'b0, "R1 reset irq");
    rst_n = 1'b1;
    @(negedge clk);
    lfa = 1'b1;

    // R3/R4 threshold sweep
    for (int n = 240; n <= 256; n++) begin
      window(n, 0, n >= 254 ? "R3 set at threshold" : "R4 clear below threshold");
      if (n >= 254) begin
        window(0, 0, "R4 clear after set");
      end
    end

    // R2 shifted stream: pairs are 0,1 -> no hits
    window(256, 0, "R3 set before shift");
    send_bit(1'b0);
    for (int i = 0; i < 255; i++) begin send_bit(1'b1); send_bit(1'b0); end
    send_bit(1'b1);
    idle_sample;
    chk(aux, 1'b0, "R2 shifted pairs do not count");

    // R7 gaps with junk on disabled cycles
    window(254, 2, "R7 disabled cycles ignored");
    window(253, 1, "R7 disabled cycles ignored below");

    // R6 alignment drop mid-window
    window(256, 0, "R3 set before drop");
    send_bit(1'b1);
    send_pairs(100, 100, 0);
    @(negedge clk); bit_en = 1'b0; lfa = 1'b0;
    @(negedge clk);
    chk(aux, 1'b0, "R6 clear while aligned");
    send_bit(1'b1); // ignored while aligned
    @(negedge clk); bit_en = 1'b0; lfa = 1'b1;
    send_pairs(156, 156, 0);
    idle_sample;
    chk(aux, 1'b0, "R6 window restarted after drop");
    send_pairs(100, 100, 0);
    idle_sample;
    chk(aux, 1'b1, "R6 full window after return");
    chk(irq, 1'b1, "R8 irq after realign set");
    irq_exp++;
    window(0, 0, "R4 clear");

    // R9/R10 simulation without real detection
    @(negedge clk); sim = 1'b1;
    @(negedge clk);
    chk(aux, 1'b1, "R9 sim forces on");
    chk(irq, 1'b1, "R9 sim irq");
    irq_exp++;
    @(negedge clk);
    chk(irq, 1'b0, "R8 irq one cycle sim");
    sim = 1'b0;
    @(negedge clk);
    chk(aux, 1'b0, "R10 release clears");

    // R9/R10 with real detection present
    window(255, 0, "R3 set");
    @(negedge clk); sim = 1'b1;
    @(negedge clk);
    chk(irq, 1'b0, "R9 no irq when already set");
    sim = 1'b0;
    @(negedge clk);
    chk(aux, 1'b1, "R10 real status kept");

    // R9 with alignment present
    lfa = 1'b0; sim = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(aux, 1'b1, "R9 sim while aligned");
    sim = 1'b0;
    @(negedge clk);
    chk(aux, 1'b0, "R10 release while aligned");

    repeat (3) @(negedge clk);
    n_run++;
    if (irq_seen != irq_exp) begin
      n_fail++;
      $display("FAIL R8 irq count: got %0d expected %0d", irq_seen, irq_exp);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule